// File: doc/BRIEF.md
# Packet Header Framer

The framer puts a one-word header in front of a stream of 64-bit payload words. A packet starts when an upstream agent hands over a header descriptor through a valid/ready handshake. The descriptor gives the packet kind, a timed flag, an end-of-burst flag, source and destination identifiers, a 64-bit timestamp and the number of payload words. The framer then emits three things on its 64-bit output stream: the header word, then the timestamp word if the packet is timed, then the payload words. The payload words pass straight through from the input stream.

The framer fills in two header fields itself. The byte length comes from the word count and the timed flag. The 12-bit sequence number is held in an internal counter that advances once for each completed packet. Every output word waits for the downstream ready. Payload ready is given to the upstream source only while payload is being forwarded. The packet ends on the input word that carries tlast, and the end marker on the output follows from that.

Top module: `pkt_framer`

## Requirements
- R1: The header word is laid out from the top bit down: bits 63:62 kind (00 data, 01 flow control, 10 command, 11 response), bit 61 timed flag, bit 60 end-of-burst flag, bits 59:48 sequence number, bits 47:32 byte length, bits 31:16 source identifier, bits 15:0 destination identifier.
- R2: For a timed packet, the word after the header is the descriptor's full 64-bit timestamp, and it comes before any payload.
- R3: The length field equals 8 times the payload word count, plus 16 for a timed packet or plus 8 for an untimed one.
- R4: Payload words are forwarded unchanged and in order. Output tlast is set only on the final payload word, which is the input word that carries tlast.
- R5: An untimed packet with no payload is a single header word with length 8 and output tlast set.
- R6: A timed packet with no payload is two words, and output tlast is set on the timestamp word only.
- R7: desc_ready is high only while no packet is in progress. Exactly one descriptor is taken per packet, and it is taken before that packet's header word appears.
- R8: The sequence number starts at 0 after reset, grows by one for each completed packet and wraps from 4095 to 0.
- R9: While out_tvalid is high and out_tready is low, out_tvalid stays high and out_tdata and out_tlast stay unchanged in the next cycle.
- R10: in_tready is low while the header or timestamp word is pending and while idle. While payload is being forwarded, in_tready equals out_tready and out_tvalid equals in_tvalid.
- R11: After reset, out_tvalid and in_tready are low and desc_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor offered |
| desc_ready | output | 1 | Descriptor taken when high with desc_valid |
| desc_kind | input | 2 | Packet kind code |
| desc_timed | input | 1 | Packet carries a timestamp word |
| desc_burst_end | input | 1 | End-of-burst flag |
| desc_src | input | 16 | Source identifier |
| desc_dst | input | 16 | Destination identifier |
| desc_stamp | input | 64 | Timestamp value |
| desc_words | input | COUNT_W | Payload word count |
| in_tdata | input | 64 | Payload data |
| in_tvalid | input | 1 | Payload word offered |
| in_tready | output | 1 | Payload word accepted |
| in_tlast | input | 1 | Final payload word |
| out_tdata | output | 64 | Framed output data |
| out_tvalid | output | 1 | Output word offered |
| out_tready | input | 1 | Downstream accepts word |
| out_tlast | output | 1 | Final word of the packet |

## Verification
The sequence wrap is the hardest case to reach from the ports: 4096 packets must complete before the counter returns to zero. The stimulus reaches it with a long run of header-only packets under constant ready, which takes two cycles per packet, and then checks the headers on both sides of the wrap. Two other cases depend on timing. One is a stall on the header or timestamp word while upstream already offers payload. The other is a bubble in the payload while downstream is ready. Random ready and random source gaps produce both, and a behavioural model checks the expected handshakes in every cycle.

// File: rtl/pkt_framer_pkg.sv
package pkt_framer_pkg;

    localparam int unsigned WORD_W = 64;
    localparam int unsigned SEQ_W  = 12;
    localparam int unsigned LEN_W  = 16;
    localparam int unsigned ID_W   = 16;

    typedef enum logic [1:0] {
        KIND_DATA = 2'b00,
        KIND_FLOW = 2'b01,
        KIND_CMD  = 2'b10,
        KIND_RESP = 2'b11
    } pkt_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HEAD,
        PH_TIME,
        PH_BODY
    } phase_e;

    typedef struct packed {
        pkt_kind_e         kind;
        logic              timed;
        logic              burst_end;
        logic [ID_W-1:0]   src;
        logic [ID_W-1:0]   dst;
        logic [WORD_W-1:0] stamp;
    } desc_t;

    // Field order is the wire order, most significant first.
    typedef struct packed {
        pkt_kind_e        kind;
        logic             timed;
        logic             burst_end;
        logic [SEQ_W-1:0] seq;
        logic [LEN_W-1:0] len;
        logic [ID_W-1:0]  src;
        logic [ID_W-1:0]  dst;
    } hdr_word_t;

    function automatic logic [LEN_W-1:0] byte_len(input logic [LEN_W-1:0] words,
                                                  input logic timed);
        logic [LEN_W-1:0] extra;
        extra = timed ? LEN_W'(16) : LEN_W'(8);
        return (words << 3) + extra;
    endfunction

endpackage

// File: rtl/pkt_seq_counter.sv
module pkt_seq_counter #(
    parameter int unsigned SEQ_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump,
    output logic [SEQ_W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
        end else if (bump) begin
            value <= value + SEQ_W'(1);
        end
    end
endmodule

// File: rtl/pkt_frame_ctrl.sv
module pkt_frame_ctrl
    import pkt_framer_pkg::*;
#(
    parameter int unsigned COUNT_W = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               desc_valid,
    input  desc_t              desc_in,
    input  logic [COUNT_W-1:0] desc_words,
    output logic               desc_ready,
    input  logic               in_tvalid,
    input  logic               in_tlast,
    input  logic               out_tready,
    output phase_e             phase,
    output desc_t              held,
    output logic [COUNT_W-1:0] held_words,
    output logic               pkt_done
);
    phase_e ph_q, ph_d;
    logic   no_body;

    assign no_body    = (held_words == '0);
    assign desc_ready = (ph_q == PH_IDLE);
    assign phase      = ph_q;

    always_comb begin
        ph_d     = ph_q;
        pkt_done = 1'b0;
        case (ph_q)
            PH_IDLE: begin
                if (desc_valid) ph_d = PH_HEAD;
            end
            PH_HEAD: begin
                if (out_tready) begin
                    if (held.timed) begin
                        ph_d = PH_TIME;
                    end else if (no_body) begin
                        ph_d     = PH_IDLE;
                        pkt_done = 1'b1;
                    end else begin
                        ph_d = PH_BODY;
                    end
                end
            end
            PH_TIME: begin
                if (out_tready) begin
                    if (no_body) begin
                        ph_d     = PH_IDLE;
                        pkt_done = 1'b1;
                    end else begin
                        ph_d = PH_BODY;
                    end
                end
            end
            PH_BODY: begin
                if (in_tvalid && out_tready && in_tlast) begin
                    ph_d     = PH_IDLE;
                    pkt_done = 1'b1;
                end
            end
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q       <= PH_IDLE;
            held       <= '0;
            held_words <= '0;
        end else begin
            ph_q <= ph_d;
            if (ph_q == PH_IDLE && desc_valid) begin
                held       <= desc_in;
                held_words <= desc_words;
            end
        end
    end
endmodule

// File: rtl/pkt_out_stage.sv
module pkt_out_stage
    import pkt_framer_pkg::*;
#(
    parameter int unsigned COUNT_W = 11
) (
    input  phase_e             phase,
    input  desc_t              held,
    input  logic [COUNT_W-1:0] held_words,
    input  logic [SEQ_W-1:0]   seq,
    input  logic [WORD_W-1:0]  in_tdata,
    input  logic               in_tvalid,
    input  logic               in_tlast,
    input  logic               out_tready,
    output logic [WORD_W-1:0]  out_tdata,
    output logic               out_tvalid,
    output logic               out_tlast,
    output logic               in_tready
);
    hdr_word_t        hdr;
    logic [LEN_W-1:0] words_ext;
    logic             no_body;

    assign words_ext = LEN_W'(held_words);
    assign no_body   = (held_words == '0);

    always_comb begin
        hdr.kind      = held.kind;
        hdr.timed     = held.timed;
        hdr.burst_end = held.burst_end;
        hdr.seq       = seq;
        hdr.len       = byte_len(words_ext, held.timed);
        hdr.src       = held.src;
        hdr.dst       = held.dst;
    end

    always_comb begin
        out_tdata  = '0;
        out_tvalid = 1'b0;
        out_tlast  = 1'b0;
        in_tready  = 1'b0;
        case (phase)
            PH_HEAD: begin
                out_tdata  = hdr;
                out_tvalid = 1'b1;
                out_tlast  = !held.timed && no_body;
            end
            PH_TIME: begin
                out_tdata  = held.stamp;
                out_tvalid = 1'b1;
                out_tlast  = no_body;
            end
            PH_BODY: begin
                out_tdata  = in_tdata;
                out_tvalid = in_tvalid;
                out_tlast  = in_tlast;
                in_tready  = out_tready;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
    import pkt_framer_pkg::*;
#(
    parameter int unsigned COUNT_W = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               desc_valid,
    output logic               desc_ready,
    input  logic [1:0]         desc_kind,
    input  logic               desc_timed,
    input  logic               desc_burst_end,
    input  logic [15:0]        desc_src,
    input  logic [15:0]        desc_dst,
    input  logic [63:0]        desc_stamp,
    input  logic [COUNT_W-1:0] desc_words,
    input  logic [63:0]        in_tdata,
    input  logic               in_tvalid,
    output logic               in_tready,
    input  logic               in_tlast,
    output logic [63:0]        out_tdata,
    output logic               out_tvalid,
    input  logic               out_tready,
    output logic               out_tlast
);
    desc_t              desc_in, held;
    phase_e             phase;
    logic [COUNT_W-1:0] held_words;
    logic               pkt_done;
    logic [SEQ_W-1:0]   seq;

    always_comb begin
        desc_in.kind      = pkt_kind_e'(desc_kind);
        desc_in.timed     = desc_timed;
        desc_in.burst_end = desc_burst_end;
        desc_in.src       = desc_src;
        desc_in.dst       = desc_dst;
        desc_in.stamp     = desc_stamp;
    end

    pkt_frame_ctrl #(.COUNT_W(COUNT_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .desc_valid (desc_valid),
        .desc_in    (desc_in),
        .desc_words (desc_words),
        .desc_ready (desc_ready),
        .in_tvalid  (in_tvalid),
        .in_tlast   (in_tlast),
        .out_tready (out_tready),
        .phase      (phase),
        .held       (held),
        .held_words (held_words),
        .pkt_done   (pkt_done)
    );

    pkt_seq_counter #(.SEQ_W(SEQ_W)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .bump  (pkt_done),
        .value (seq)
    );

    pkt_out_stage #(.COUNT_W(COUNT_W)) u_out (
        .phase      (phase),
        .held       (held),
        .held_words (held_words),
        .seq        (seq),
        .in_tdata   (in_tdata),
        .in_tvalid  (in_tvalid),
        .in_tlast   (in_tlast),
        .out_tready (out_tready),
        .out_tdata  (out_tdata),
        .out_tvalid (out_tvalid),
        .out_tlast  (out_tlast),
        .in_tready  (in_tready)
    );
endmodule

// File: rtl/pkt_framer_chk.sv
module pkt_framer_chk (
    input logic        clk,
    input logic        rst,
    input logic        desc_valid,
    input logic        desc_ready,
    input logic        in_tready,
    input logic [63:0] out_tdata,
    input logic        out_tvalid,
    input logic        out_tready,
    input logic        out_tlast
);
    logic        first_q;
    logic [11:0] exp_seq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q   <= 1'b1;
            exp_seq_q <= '0;
        end else if (out_tvalid && out_tready) begin
            first_q <= out_tlast;
            if (out_tlast) exp_seq_q <= exp_seq_q + 12'd1;
        end
    end

    // R8: header sequence field follows the completed-packet count
    a_r8_seq_track: assert property (@(posedge clk) disable iff (rst)
        first_q && out_tvalid |-> out_tdata[59:48] == exp_seq_q);

    // R5: a header that also ends the packet carries length 8
    a_r5_hdr_only_len: assert property (@(posedge clk) disable iff (rst)
        first_q && out_tvalid && out_tlast |-> out_tdata[47:32] == 16'd8);

    // R3: length is a whole number of words and at least one word
    a_r3_len_shape: assert property (@(posedge clk) disable iff (rst)
        first_q && out_tvalid |-> out_tdata[34:32] == 3'd0 && out_tdata[47:32] >= 16'd8);

    // R9: stalled output holds
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        out_tvalid && !out_tready |=> out_tvalid && $stable(out_tdata) && $stable(out_tlast));

    // R10: payload ready never rises without downstream ready
    a_r10_ready_gate: assert property (@(posedge clk) disable iff (rst)
        in_tready |-> out_tready);

    // R7: a taken descriptor closes the descriptor port
    a_r7_one_desc: assert property (@(posedge clk) disable iff (rst)
        desc_valid && desc_ready |=> !desc_ready);
endmodule

bind pkt_framer pkt_framer_chk u_chk (.*);

// File: tb/sim_pkt_framer.sv
module sim_pkt_framer;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 11;

    typedef struct packed {
        logic [63:0] d;
        logic        l;
        logic        pay;
        logic        hdr;
        logic [7:0]  req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          desc_valid = 1'b0;
    logic          desc_ready;
    logic [1:0]    desc_kind = '0;
    logic          desc_timed = 1'b0;
    logic          desc_burst_end = 1'b0;
    logic [15:0]   desc_src = '0;
    logic [15:0]   desc_dst = '0;
    logic [63:0]   desc_stamp = '0;
    logic [CW-1:0] desc_words = '0;
    logic [63:0]   in_tdata = '0;
    logic          in_tvalid = 1'b0;
    logic          in_tready;
    logic          in_tlast = 1'b0;
    logic [63:0]   out_tdata;
    logic          out_tvalid;
    logic          out_tready = 1'b0;
    logic          out_tlast;

    pkt_framer #(.COUNT_W(CW)) u0 (
        .clk(clk), .rst(rst),
        .desc_valid(desc_valid), .desc_ready(desc_ready),
        .desc_kind(desc_kind), .desc_timed(desc_timed), .desc_burst_end(desc_burst_end),
        .desc_src(desc_src), .desc_dst(desc_dst), .desc_stamp(desc_stamp),
        .desc_words(desc_words),
        .in_tdata(in_tdata), .in_tvalid(in_tvalid), .in_tready(in_tready), .in_tlast(in_tlast),
        .out_tdata(out_tdata), .out_tvalid(out_tvalid), .out_tready(out_tready), .out_tlast(out_tlast)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int          errors = 0;
    int          checks = 0;
    int          rdy_pct = 100;
    int          bub_pct = 0;
    int          pending = 0;
    bit          run_on = 1'b0;
    bit          finished = 1'b0;
    logic [11:0] seq_m = '0;
    exp_t        exp_q[$];
    logic [63:0] pay_q[$];
    logic        prev_hold = 1'b0;
    logic [63:0] prev_d = '0;
    logic        prev_l = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Sink: ready changes just after the rising edge
    initial forever begin
        @(posedge clk);
        #1;
        out_tready = (int'($urandom % 100) < rdy_pct);
    end

    // Reference model, evaluated at every falling edge
    always @(negedge clk) begin
        if (run_on && !finished) begin
            bit   fp;
            exp_t e;
            fp = (pending > 0) && (exp_q.size() > 0) && exp_q[0].pay;
            if (prev_hold)  // R9
                chk(out_tvalid && out_tdata == prev_d && out_tlast == prev_l, "R9 hold",
                    out_tdata, prev_d);
            // R7: descriptor port open only when no packet is in progress
            chk(desc_ready == (pending == 0), "R7 desc_ready", 64'(desc_ready), 64'(pending == 0));
            // R10: payload ready gating
            if (fp) chk(in_tready == out_tready, "R10 in_tready", 64'(in_tready), 64'(out_tready));
            else    chk(in_tready == 1'b0, "R10 in_tready", 64'(in_tready), 64'd0);
            if (pending == 0)  // R11 idle output
                chk(out_tvalid == 1'b0, "R11 idle valid", 64'(out_tvalid), 64'd0);
            else if (!fp)
                chk(out_tvalid == 1'b1, "R9 framing valid", 64'(out_tvalid), 64'd1);
            else
                chk(out_tvalid == in_tvalid, "R10 pass valid", 64'(out_tvalid), 64'(in_tvalid));
            if (out_tvalid && out_tready) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected word", out_tdata, 64'd0);
                end else begin
                    e = exp_q.pop_front();
                    // tags: R1 header, R2 timestamp, R4 payload, R5 header-only, R6 timestamp-only
                    chk(out_tdata == e.d && out_tlast == e.l, $sformatf("R%0d word", e.req),
                        {out_tdata[62:0], out_tlast}, {e.d[62:0], e.l});
                    if (e.hdr) begin
                        chk(out_tdata[59:48] == e.d[59:48], "R8 seq", 64'(out_tdata[59:48]),
                            64'(e.d[59:48]));
                        chk(out_tdata[47:32] == e.d[47:32], "R3 length", 64'(out_tdata[47:32]),
                            64'(e.d[47:32]));
                    end
                    if (e.l) pending--;
                end
            end
            if (desc_valid && desc_ready) pending++;
            prev_hold = out_tvalid && !out_tready;
            prev_d    = out_tdata;
            prev_l    = out_tlast;
        end
    end

    task automatic send_pkt(input logic [1:0] k, input logic ht, input logic eob,
                            input logic [15:0] s, input logic [15:0] dd,
                            input logic [63:0] ts, input int n);
        logic [15:0] len;
        logic [63:0] w;
        len = 16'(8 * n + (ht ? 16 : 8));
        exp_q.push_back('{d: {k, ht, eob, seq_m, len, s, dd}, l: (!ht && n == 0),
                          pay: 1'b0, hdr: 1'b1, req: ((!ht && n == 0) ? 8'd5 : 8'd1)});
        if (ht)
            exp_q.push_back('{d: ts, l: (n == 0), pay: 1'b0, hdr: 1'b0,
                              req: ((n == 0) ? 8'd6 : 8'd2)});
        for (int i = 0; i < n; i++) begin
            w = {$urandom, $urandom};
            pay_q.push_back(w);
            exp_q.push_back('{d: w, l: (i == n - 1), pay: 1'b1, hdr: 1'b0, req: 8'd4});
        end
        seq_m = seq_m + 12'd1;
        desc_kind = k; desc_timed = ht; desc_burst_end = eob;
        desc_src = s; desc_dst = dd; desc_stamp = ts; desc_words = CW'(n);
        desc_valid = 1'b1;
        do @(negedge clk); while (!desc_ready);
        @(posedge clk);
        #1;
        desc_valid = 1'b0;
        desc_stamp = {$urandom, $urandom};  // descriptor changes after capture
        for (int i = 0; i < n; i++) begin
            if (int'($urandom % 100) < bub_pct) begin
                in_tvalid = 1'b0;
                @(posedge clk);
                #1;
            end
            in_tvalid = 1'b1;
            in_tdata  = pay_q.pop_front();
            in_tlast  = (i == n - 1);
            do @(negedge clk); while (!in_tready);
            @(posedge clk);
            #1;
        end
        in_tvalid = 1'b0;
        in_tlast  = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        // R11: state right after reset
        chk(out_tvalid == 1'b0, "R11 reset valid", 64'(out_tvalid), 64'd0);
        chk(in_tready == 1'b0, "R11 reset in_tready", 64'(in_tready), 64'd0);
        chk(desc_ready == 1'b1, "R11 reset desc_ready", 64'(desc_ready), 64'd1);
        run_on = 1'b1;
        @(posedge clk);
        #1;
        // R1 and R5: each kind as a header-only packet
        send_pkt(2'b00, 1'b0, 1'b0, 16'h1234, 16'hABCD, 64'h0, 0);
        send_pkt(2'b01, 1'b0, 1'b1, 16'h0001, 16'h8000, 64'h0, 0);
        send_pkt(2'b10, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 64'h0, 0);
        send_pkt(2'b11, 1'b0, 1'b1, 16'h5A5A, 16'hA5A5, 64'h0, 0);
        rdy_pct = 50;
        // R6 timestamp only, R2 timed with payload
        send_pkt(2'b00, 1'b1, 1'b0, 16'h0010, 16'h0020, 64'hDEADBEEF_01234567, 0);
        send_pkt(2'b00, 1'b1, 1'b1, 16'h0011, 16'h0021, 64'hFFFFFFFF_FFFFFFFF, 1);
        send_pkt(2'b10, 1'b1, 1'b0, 16'h0012, 16'h0022, 64'h00000000_00000001, 3);
        // R4 untimed payload
        send_pkt(2'b00, 1'b0, 1'b0, 16'h0013, 16'h0023, 64'h0, 1);
        send_pkt(2'b01, 1'b0, 1'b0, 16'h0014, 16'h0024, 64'h0, 5);
        bub_pct = 30;
        rdy_pct = 60;
        send_pkt(2'b00, 1'b1, 1'b0, 16'h0100, 16'h0200, 64'h13579BDF_2468ACE0, 40);
        send_pkt(2'b11, 1'b0, 1'b1, 16'h0101, 16'h0201, 64'h0, 17);
        rdy_pct = 25;
        send_pkt(2'b00, 1'b0, 1'b0, 16'h0102, 16'h0202, 64'h0, 8);
        send_pkt(2'b01, 1'b0, 1'b0, 16'h0103, 16'h0203, 64'h0, 0);
        send_pkt(2'b10, 1'b1, 1'b0, 16'h0104, 16'h0204, 64'hCAFEF00D_CAFEF00D, 0);
        // R8: run the sequence number through its wrap
        rdy_pct = 100;
        bub_pct = 0;
        for (int i = 0; i < 4100; i++)
            send_pkt(2'(i), 1'b0, 1'(i >> 2), 16'(i), 16'(~i), 64'h0, 0);
        rdy_pct = 70;
        send_pkt(2'b00, 1'b1, 1'b0, 16'h7777, 16'h8888, 64'h0000FFFF_0000FFFF, 2);
        while (exp_q.size() != 0) @(posedge clk);
        repeat (5) @(posedge clk);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL R7 watchdog actual=hung expected=complete");
            summary();
            $finish;
        end
    end
endmodule